// File: doc/BRIEF.md
# Four-Channel Pulse-Width Generator with Boundary-Synchronised Updates

This block produces four independent pulse-width modulated outputs. Each channel is configured through two 32-bit registers on a simple single-cycle register bus. One register holds the number of clock cycles the output stays high at the start of every cycle. The other holds the total cycle length in clock cycles. Software writes a register by presenting a byte address, data and a write strobe for one clock edge. A read returns data combinationally for whatever address is presented.

Every written value lands first in a per-channel software copy. A separate active copy drives the counter. While a channel is generating, the active copy is refreshed only when the running cycle ends, so rewriting one register in the middle of a cycle never produces a cycle that mixes old and new values. A channel whose active cycle length is zero is idle and holds its output high. An idle channel picks up a nonzero configuration on the next clock edge, without waiting for a boundary. After reset every register reads zero and every output is high.

Top module: `pwm_quad`

## Requirements
- R1: While reset is asserted and after it is released, all eight registers read 0 and all four outputs are high.
- R2: With active cycle length P > 0 and high count H < P, the output is high for the first H clocks of each cycle and low for the remaining P−H clocks. The cycle repeats every P clocks.
- R3: If H ≥ P with P > 0, the output stays high for the whole cycle.
- R4: If H = 0 with P > 0, the output stays low for the whole cycle.
- R5: A channel whose active cycle length is 0 holds its output high, whatever its high count is. Writing 0 to the cycle length of a running channel returns the output to idle-high once the current cycle ends.
- R6: Channel c has its high-count register at byte offset 8·c and its cycle-length register at offset 8·c+4. Address bits [1:0] are ignored. Each register reads back the last 32-bit value written to it.
- R7: A write to either register of a running channel does not change the cycle in progress. The new values take effect from the first clock of the next cycle.
- R8: When a channel is idle, a write of a nonzero cycle length is taken into the active copy at the next clock edge. The output then follows the new waveform from that edge onward.
- R9: Writes to byte addresses at or above 0x20 change no register. Reads from those addresses return 0.
- R10: Configuring one channel has no effect on the registers or the output of any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all counting is in periods of this clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | Channel outputs, bit c belongs to channel c |

## Verification
The bench rewrites a channel in the middle of a cycle, after its high phase has begun. A design that applied the write at once would drive the output high in a cycle that must still go low. It programs an idle channel with a zero high count and checks the output one clock later. A design that waited for a boundary would stay high there. It stores a large high count beside a zero cycle length, and writes a cycle length of zero to a running channel. These catch designs that treat a nonzero high count as running, or that drop to low instead of idle-high. It also writes just past the register window. A decoder that wrapped the channel index would then corrupt channel 0.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    localparam int DATA_W     = 32;
    localparam int GROUP_SPAN = 8;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        word_t high_len;
        word_t cycle_len;
    } pwm_cfg_t;

    typedef enum logic {
        SEL_HIGH  = 1'b0,
        SEL_CYCLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        logic [7:0] chan;
        reg_sel_e sel;
    } reg_decode_t;

    function automatic reg_decode_t decode_addr(input logic [31:0] byte_addr,
                                                input int unsigned num_ch);
        reg_decode_t d;
        d.hit  = (byte_addr < num_ch * GROUP_SPAN);
        d.chan = byte_addr[10:3];
        d.sel  = reg_sel_e'(byte_addr[2]);
        return d;
    endfunction

    function automatic logic pwm_level(input pwm_cfg_t act, input word_t count);
        if (act.cycle_len == '0)
            return 1'b1;
        return (count < act.high_len);
    endfunction

endpackage

// File: rtl/pwmc_regbank.sv
module pwmc_regbank
    import pwmc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output pwm_cfg_t [NUM_CH-1:0]       cfg_q
);

    reg_decode_t dec;

    always_comb begin
        dec = decode_addr(32'(bus_addr), NUM_CH);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_grp
        logic sel_me;
        always_comb begin
            sel_me = dec.hit && (int'(dec.chan) == c);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[c] <= '0;
            end else if (bus_wr && sel_me) begin
                if (dec.sel == SEL_HIGH)
                    cfg_q[c].high_len <= bus_wdata;
                else
                    cfg_q[c].cycle_len <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (dec.hit && int'(dec.chan) == c) begin
                bus_rdata = (dec.sel == SEL_HIGH) ? cfg_q[c].high_len
                                                  : cfg_q[c].cycle_len;
            end
        end
    end

endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel
    import pwmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pwm_cfg_t cfg,
    output pwm_cfg_t act,
    output word_t    count,
    output logic     pwm_o
);

    logic idle;
    logic wrap;

    always_comb begin
        idle = (act.cycle_len == '0);
        wrap = !idle && (count == act.cycle_len - word_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act   <= '0;
            count <= '0;
        end else if (idle || wrap) begin
            act   <= cfg;
            count <= '0;
        end else begin
            count <= count + word_t'(1);
        end
    end

    always_comb begin
        pwm_o = pwm_level(act, count);
    end

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwmc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_CH-1:0]   pwm_out
);

    pwm_cfg_t [NUM_CH-1:0] cfg_w;
    pwm_cfg_t [NUM_CH-1:0] act_w;
    word_t    [NUM_CH-1:0] cnt_w;

    pwmc_regbank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_q     (cfg_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwmc_channel u_ch (
            .clk   (clk),
            .rst   (rst),
            .cfg   (cfg_w[c]),
            .act   (act_w[c]),
            .count (cnt_w[c]),
            .pwm_o (pwm_out[c])
        );
    end

endmodule

// File: rtl/pwmc_checker.sv
module pwmc_checker
    import pwmc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [NUM_CH-1:0]     pwm_out,
    input pwm_cfg_t [NUM_CH-1:0] cfg_w,
    input pwm_cfg_t [NUM_CH-1:0] act_w,
    input word_t [NUM_CH-1:0]    cnt_w
);

    assert_reset_high_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pwm_out == {NUM_CH{1'b1}}));

    assert_oob_read_R9: assert property (@(posedge clk) disable iff (rst)
        (32'(bus_addr) >= NUM_CH * GROUP_SPAN) |-> (bus_rdata == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
            (act_w[c].cycle_len != '0) |-> (cnt_w[c] < act_w[c].cycle_len));

        assert_full_high_R3: assert property (@(posedge clk) disable iff (rst)
            (act_w[c].cycle_len != '0 && act_w[c].high_len >= act_w[c].cycle_len)
            |-> pwm_out[c]);

        assert_zero_high_R4: assert property (@(posedge clk) disable iff (rst)
            (act_w[c].cycle_len != '0 && act_w[c].high_len == '0) |-> !pwm_out[c]);

        assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
            (act_w[c].cycle_len == '0) |-> pwm_out[c]);

        assert_hold_midcycle_R7: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(act_w[c].cycle_len) != '0 &&
             $past(cnt_w[c]) != $past(act_w[c].cycle_len) - word_t'(1))
            |-> $stable(act_w[c]));

        assert_idle_load_R8: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(act_w[c].cycle_len) == '0)
            |-> (act_w[c] == $past(cfg_w[c])));
    end

endmodule

bind pwm_quad pwmc_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .cfg_w     (cfg_w),
    .act_w     (act_w),
    .cnt_w     (cnt_w)
);

// File: tb/pwm_quad_test.sv
module pwm_quad_test;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // behavioural reference: software copy, active copy, position in cycle
    logic [31:0] m_sw_hi  [NCH];
    logic [31:0] m_sw_len [NCH];
    logic [31:0] m_hi     [NCH];
    logic [31:0] m_len    [NCH];
    longint      m_pos    [NCH];

    pwm_quad uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #10 clk = ~clk;

    function automatic logic model_out(int c);
        if (m_len[c] == 0) return 1'b1;
        return (m_pos[c] < longint'(m_hi[c]));
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        if (a >= 8'h20) return 32'h0;
        return a[2] ? m_sw_len[a[4:3]] : m_sw_hi[a[4:3]];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        for (int c = 0; c < NCH; c++) begin
            if (rst) begin
                m_sw_hi[c] = 0; m_sw_len[c] = 0;
                m_hi[c] = 0; m_len[c] = 0; m_pos[c] = 0;
            end else if (m_len[c] == 0 || m_pos[c] == longint'(m_len[c]) - 1) begin
                m_hi[c] = m_sw_hi[c]; m_len[c] = m_sw_len[c]; m_pos[c] = 0;
            end else begin
                m_pos[c]++;
            end
        end
        if (!rst && bus_wr && bus_addr < 8'h20) begin
            if (bus_addr[2]) m_sw_len[bus_addr[4:3]] = bus_wdata;
            else             m_sw_hi[bus_addr[4:3]]  = bus_wdata;
        end
    end

    // every-clock comparison of all outputs against the reference (R2)
    always @(negedge clk) begin
        if (cycles > 0) begin
            for (int c = 0; c < NCH; c++)
                check($sformatf("R2 ch%0d waveform", c), 32'(pwm_out[c]), 32'(model_out(c)));
        end
    end

    always @(posedge clk) begin
        if (cycles > 20000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [7:0] a);
        bus_addr = a;
        #1;
        check(req, bus_rdata, model_read(a));
    endtask

    initial begin
        int hi_cnt;
        repeat (3) @(negedge clk);
        // R1: state during and after reset
        check("R1 outputs in reset", 32'(pwm_out), 32'hF);
        rst = 1'b0;
        @(negedge clk);
        for (int r = 0; r < 8; r++) begin
            bus_addr = 8'(r * 4); #1;
            check("R1 register after reset", bus_rdata, 32'h0);
        end
        check("R1 outputs after reset", 32'(pwm_out), 32'hF);

        // R5/R6: large high count with zero cycle length stays idle-high
        wr(8'h18, 32'hDEADBEEF);
        rd_check("R6 ch3 high readback", 8'h18);
        check("R6 ch3 high value", bus_rdata, 32'hDEADBEEF);
        wr(8'h1F, 32'h0);  // low bits ignored: cycle length of ch3 = 0
        rd_check("R6 ch3 cycle readback", 8'h1C);
        repeat (3) @(negedge clk);
        check("R5 ch3 idle high", 32'(pwm_out[3]), 32'h1);

        // R8 and R4: idle channel 1 with zero high count starts at once
        wr(8'h0C, 32'd5);
        @(negedge clk);
        check("R8 ch1 low one clock after load", 32'(pwm_out[1]), 32'h0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R4 ch1 constant low", 32'(pwm_out[1]), 32'h0);
        end

        // R2: ch2 high 2 of every 5 clocks
        wr(8'h10, 32'd2);
        wr(8'h14, 32'd5);
        hi_cnt = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            hi_cnt += int'(pwm_out[2]);
        end
        check("R2 ch2 high clocks in two cycles", 32'(hi_cnt), 32'd4);

        // R7 and R3: rewrite ch0 after its cycle has started
        wr(8'h00, 32'd3);
        wr(8'h04, 32'd8);
        wr(8'h00, 32'd8);
        repeat (3) @(negedge clk);
        check("R7 ch0 old low phase kept", 32'(pwm_out[0]), 32'h0);
        repeat (5) @(negedge clk);
        check("R3 ch0 high at new cycle start", 32'(pwm_out[0]), 32'h1);
        repeat (4) @(negedge clk);
        check("R3 ch0 high mid cycle", 32'(pwm_out[0]), 32'h1);

        // R9: writes past the window are dropped, reads give 0
        wr(8'h20, 32'h12345678);
        wr(8'h24, 32'hFFFFFFFF);
        wr(8'hFC, 32'hA5A5A5A5);
        rd_check("R9 read 0x20", 8'h20);
        rd_check("R9 read 0xFC", 8'hFC);
        rd_check("R9 ch0 high untouched", 8'h00);
        rd_check("R9 ch0 cycle untouched", 8'h04);

        // R10: other channels unaffected by all of the above
        for (int r = 0; r < 8; r++) rd_check("R10 register isolation", 8'(r * 4));
        wr(8'h00, 32'd1);
        check("R10 ch3 unaffected by ch0 write", 32'(pwm_out[3]), 32'h1);

        // R5: stopping a running channel returns to idle-high at boundary
        wr(8'h0C, 32'd0);
        repeat (7) @(negedge clk);
        check("R5 ch1 idle high after stop", 32'(pwm_out[1]), 32'h1);
        repeat (20) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule